// File: doc/BRIEF.md
# Generalized Bit-Reverse Permutation Unit

This block rearranges the bits of a source word under a small control value k: result bit i is taken from source bit (i XOR k). One such index map covers every power-of-two swap pattern at once. Adjacent bits, pairs, nibbles, bytes, half-words and the two halves of the word can each be exchanged, and k with every bit set reverses the word completely. Because i XOR k is symmetric under the index mirror, numbering bits from the MSB or from the LSB gives the same mapping.

k comes either from the low bits of a register control operand or from an immediate field. A full-width mode permutes all XLEN bits. A half-width word mode permutes only the low XLEN/2 bits, uses one fewer bit of k, and clears the upper half of the result. A record-form bit asks for a one-hot sign classification of the signed result. The result, the flags and a valid strobe appear one clock after the request.

Top module: `grev_unit`

## Requirements
- R1: In full-width register mode (imm_sel=0, word_mode=0), res bit i equals src bit (i XOR k), where k = ctl_reg[log2(XLEN)-1:0]; higher ctl_reg bits have no effect.
- R2: In full-width immediate mode (imm_sel=1, word_mode=0), k = imm[log2(XLEN)-1:0] of the 6-bit imm field, and ctl_reg has no effect.
- R3: In word register mode (imm_sel=0, word_mode=1), res bit i for i < XLEN/2 equals src bit (i XOR k), where k = ctl_reg[log2(XLEN)-2:0]; ctl_reg bit log2(XLEN)-1 and above have no effect.
- R4: In word immediate mode (imm_sel=1, word_mode=1), k = imm[log2(XLEN)-2:0], and imm bit log2(XLEN)-1 has no effect.
- R5: In word mode, res[XLEN-1:XLEN/2] is zero whatever src[XLEN-1:XLEN/2] holds.
- R6: k = 0 returns the source unchanged, and k with all its bits set reverses the word (full mode) or the low half (word mode).
- R7: A request accepted with in_valid=1 at a rising edge produces res and res_valid=1 after that same edge; res_valid is 0 after any edge where in_valid was 0.
- R8: While in_valid is 0, res and flags keep their last values.
- R9: With rec_form=1, flags = {neg, pos, zero} (bit 2 neg, bit 1 pos, bit 0 zero) classifies res as a signed two's-complement value, with exactly one bit set.
- R10: With rec_form=0, flags is 3'b000.
- R11: While rst_n is low, res, flags and res_valid are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src | input | XLEN | Source word to permute |
| ctl_reg | input | XLEN | Register control operand; low bits give k |
| imm | input | IMM_W | Immediate control field; low bits give k |
| imm_sel | input | 1 | 1 takes k from imm, 0 from ctl_reg |
| word_mode | input | 1 | 1 selects the half-width zero-extending mode |
| rec_form | input | 1 | 1 requests sign flags |
| res | output | XLEN | Registered permuted result |
| flags | output | 3 | {neg, pos, zero} of res when rec_form was 1 |
| res_valid | output | 1 | res and flags hold a new result |

## Verification
The hardest case to reach is word mode with the top bit of the full-width k set and the upper source half filled with ones. A faulty design would then swap halves or leak upper bits, yet an ordinary operand hides the fault. The word-mode tasks therefore drive src with both halves non-zero and distinct, and set ctl_reg or imm bit log2(XLEN)-1 along with the bits above it. The negative flag needs a set MSB, which word mode can never produce, so the flag task uses full-width permutations that move a chosen bit into the top position.

// File: rtl/grev_pkg.sv
package grev_pkg;

   typedef struct packed {
      logic neg;
      logic pos;
      logic zero;
   } grev_flags_t;

   localparam int GREV_FLAG_W = 3;

endpackage

// File: rtl/grev_swap_net.sv
module grev_swap_net #(
   parameter int W = 64,
   localparam int L = $clog2(W)
) (
   input  logic [W-1:0] din,
   input  logic [L-1:0] k,
   output logic [W-1:0] dout
);

   if ((1 << L) != W || W < 2) begin : g_bad_width
      $error("grev_swap_net: W must be a power of two of at least 2");
   end

   logic [W-1:0] lvl [0:L];

   assign lvl[0] = din;

   for (genvar j = 0; j < L; j++) begin : g_stage
      for (genvar b = 0; b < W; b++) begin : g_bit
         assign lvl[j+1][b] = k[j] ? lvl[j][b ^ (1 << j)] : lvl[j][b];
      end
   end

   assign dout = lvl[L];

   // a permutation moves bits, never creates or drops them
   always_comb begin
      if (!$isunknown(din) && !$isunknown(k)) begin
         AST_BITS_CONSERVED: assert ($countones(dout) == $countones(din)); // R1
      end
   end

endmodule

// File: rtl/grev_flag_gen.sv
module grev_flag_gen
   import grev_pkg::*;
#(
   parameter int W = 64
) (
   input  logic [W-1:0] value,
   input  logic         enable,
   output grev_flags_t  flags
);

   logic is_zero;
   logic is_neg;

   assign is_zero = (value == '0);
   assign is_neg  = value[W-1];

   always_comb begin
      flags = '0;
      if (enable) begin
         flags.neg  = is_neg;
         flags.zero = is_zero;
         flags.pos  = !is_neg && !is_zero;
      end
   end

endmodule

// File: rtl/grev_unit.sv
module grev_unit
   import grev_pkg::*;
#(
   parameter int XLEN       = 64,
   parameter int IMM_W      = 6,
   parameter bit SHARED_NET = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [XLEN-1:0]  src,
   input  logic [XLEN-1:0]  ctl_reg,
   input  logic [IMM_W-1:0] imm,
   input  logic             imm_sel,
   input  logic             word_mode,
   input  logic             rec_form,
   output logic [XLEN-1:0]  res,
   output logic [2:0]       flags,
   output logic             res_valid
);

   localparam int L  = $clog2(XLEN);
   localparam int H  = XLEN / 2;
   localparam int LH = L - 1;

   if ((1 << L) != XLEN || XLEN < 4) begin : g_bad_xlen
      $error("grev_unit: XLEN must be a power of two of at least 4");
   end
   if (IMM_W < L) begin : g_bad_imm
      $error("grev_unit: IMM_W too narrow for log2(XLEN)");
   end

   // control selection
   logic [L-1:0]  k_full;
   logic [LH-1:0] k_half;

   assign k_full = imm_sel ? imm[L-1:0] : ctl_reg[L-1:0];
   assign k_half = k_full[LH-1:0];

   // permutation variants
   logic [XLEN-1:0] perm_next;

   if (SHARED_NET) begin : g_shared
      logic [L-1:0]    k_eff;
      logic [XLEN-1:0] net_out;

      // clearing the top k bit keeps every swap inside its own half
      assign k_eff = word_mode ? {1'b0, k_half} : k_full;

      grev_swap_net #(.W(XLEN)) u_net (
         .din  (src),
         .k    (k_eff),
         .dout (net_out)
      );

      assign perm_next = word_mode ? {{H{1'b0}}, net_out[H-1:0]} : net_out;
   end else begin : g_split
      logic [XLEN-1:0] full_out;
      logic [H-1:0]    half_out;

      grev_swap_net #(.W(XLEN)) u_full (
         .din  (src),
         .k    (k_full),
         .dout (full_out)
      );

      grev_swap_net #(.W(H)) u_half (
         .din  (src[H-1:0]),
         .k    (k_half),
         .dout (half_out)
      );

      assign perm_next = word_mode ? {{H{1'b0}}, half_out} : full_out;
   end

   // flag generation on the next result
   grev_flags_t flags_next;

   grev_flag_gen #(.W(XLEN)) u_flags (
      .value  (perm_next),
      .enable (rec_form),
      .flags  (flags_next)
   );

   // output register
   logic [XLEN-1:0] res_q;
   grev_flags_t     flags_q;
   logic            vld_q;
   logic            word_q;
   logic            rec_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q   <= '0;
         flags_q <= '0;
         vld_q   <= 1'b0;
         word_q  <= 1'b0;
         rec_q   <= 1'b0;
      end else begin
         vld_q <= in_valid;
         if (in_valid) begin
            res_q   <= perm_next;
            flags_q <= flags_next;
            word_q  <= word_mode;
            rec_q   <= rec_form;
         end
      end
   end

   assign res       = res_q;
   assign flags     = flags_q;
   assign res_valid = vld_q;

   // output-side checks
   AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && word_q) |-> (res[XLEN-1:H] == '0)); // R5

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> res_valid); // R7

   AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !res_valid); // R7

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(res) && $stable(flags))); // R8

   AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && rec_q) |-> ($countones(flags) == 1)); // R9

   AST_FLAGS_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && rec_q) |-> (flags[2] == res[XLEN-1] && flags[0] == (res == '0))); // R9

   AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !rec_q) |-> (flags == 3'b000)); // R10

endmodule

// File: tb/grev_unit_bench.sv
module grev_unit_bench;

   localparam int XLEN = 64;
   localparam int H    = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             in_valid = 1'b0;
   logic [XLEN-1:0]  src = '0;
   logic [XLEN-1:0]  ctl_reg = '0;
   logic [5:0]       imm = '0;
   logic             imm_sel = 1'b0;
   logic             word_mode = 1'b0;
   logic             rec_form = 1'b0;
   logic [XLEN-1:0]  res;
   logic [2:0]       flags;
   logic             res_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   grev_unit #(.XLEN(XLEN)) u_grev_unit (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .src       (src),
      .ctl_reg   (ctl_reg),
      .imm       (imm),
      .imm_sel   (imm_sel),
      .word_mode (word_mode),
      .rec_form  (rec_form),
      .res       (res),
      .flags     (flags),
      .res_valid (res_valid)
   );

   function automatic logic [XLEN-1:0] model(input logic [XLEN-1:0] s,
                                             input int k, input bit wm);
      logic [XLEN-1:0] r;
      r = '0;
      if (wm) begin
         for (int i = 0; i < H; i++) r[i] = s[i ^ (k & 31)];
      end else begin
         for (int i = 0; i < XLEN; i++) r[i] = s[i ^ (k & 63)];
      end
      return r;
   endfunction

   function automatic logic [2:0] flag_model(input logic [XLEN-1:0] r, input bit rf);
      if (!rf) return 3'b000;
      if (r == '0) return 3'b001;
      if (r[XLEN-1]) return 3'b100;
      return 3'b010;
   endfunction

   task automatic check(input string req, input logic [XLEN-1:0] act,
                        input logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive at negedge, sample at the following negedge
   task automatic issue(input logic [XLEN-1:0] s, input logic [XLEN-1:0] c,
                        input logic [5:0] im, input bit isel, input bit wm, input bit rf);
      @(negedge clk);
      src = s; ctl_reg = c; imm = im; imm_sel = isel; word_mode = wm; rec_form = rf;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic t_reset;
      check("R11 res", res, '0);
      check("R11 flags", {61'd0, flags}, '0);
      check("R11 valid", {63'd0, res_valid}, '0);
   endtask

   task automatic t_full_reg;
      logic [XLEN-1:0] s;
      s = 64'h0123_4567_89AB_CDEF;
      foreach (s[n]) ;
      for (int k = 1; k < 64; k += 7) begin
         issue(s, {58'h2AA_AAAA_AAAA_AAAA >> 0, 6'(k)}, 6'h15, 1'b0, 1'b0, 1'b0);
         check("R1 full reg", res, model(s, k, 1'b0));
         check("R7 valid", {63'd0, res_valid}, 64'd1);
      end
   endtask

   task automatic t_full_imm;
      logic [XLEN-1:0] s;
      s = 64'hF00F_1234_0000_ABCD;
      for (int k = 0; k < 64; k += 9) begin
         issue(s, 64'hFFFF_FFFF_FFFF_FFC5, 6'(k), 1'b1, 1'b0, 1'b0);
         check("R2 full imm", res, model(s, k, 1'b0));
      end
   endtask

   task automatic t_word_reg;
      logic [XLEN-1:0] s;
      s = 64'hFFFF_FFFF_1357_9BDF;
      for (int k = 0; k < 32; k += 5) begin
         issue(s, {58'h3FF_FFFF_FFFF_FFFF, 1'b1, 5'(k)}, 6'h00, 1'b0, 1'b1, 1'b0);
         check("R3 word reg", res, model(s, k, 1'b1));
         check("R5 upper zero", {32'd0, res[63:32]}, '0);
      end
   endtask

   task automatic t_word_imm;
      logic [XLEN-1:0] s;
      s = 64'hA5A5_5A5A_0F0F_3C3C;
      for (int k = 0; k < 32; k += 3) begin
         issue(s, 64'h3F, {1'b1, 5'(k)}, 1'b1, 1'b1, 1'b0);
         check("R4 word imm", res, model(s, k, 1'b1));
      end
   endtask

   task automatic t_reverse;
      logic [XLEN-1:0] s, rv;
      s = 64'h8000_0000_0000_0003;
      for (int i = 0; i < XLEN; i++) rv[i] = s[XLEN-1-i];
      issue(s, 64'h3F, 6'h0, 1'b0, 1'b0, 1'b0);
      check("R6 full reverse", res, rv);
      issue(s, 64'h0, 6'h0, 1'b0, 1'b0, 1'b0);
      check("R6 identity", res, s);
      issue(s, 64'h0, 6'h1F, 1'b1, 1'b1, 1'b0);
      check("R6 half reverse", res, 64'h0000_0000_C000_0000);
   endtask

   task automatic t_hold;
      logic [XLEN-1:0] prev;
      logic [2:0]      pflags;
      issue(64'h1, 64'h3F, 6'h0, 1'b0, 1'b0, 1'b1);
      prev = res; pflags = flags;
      src = 64'hDEAD_BEEF_DEAD_BEEF; ctl_reg = 64'h5; rec_form = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R8 hold res", res, prev);
      check("R8 hold flags", {61'd0, flags}, {61'd0, pflags});
      check("R7 idle valid", {63'd0, res_valid}, 64'd0);
   endtask

   task automatic t_flags;
      // bit 0 moved to MSB by k = 63 -> negative
      issue(64'h1, 64'h3F, 6'h0, 1'b0, 1'b0, 1'b1);
      check("R9 neg", {61'd0, flags}, {61'd0, flag_model(model(64'h1, 63, 1'b0), 1'b1)});
      check("R9 neg code", {61'd0, flags}, 64'd4);
      issue(64'h1, 64'h0, 6'h2, 1'b1, 1'b0, 1'b1);
      check("R9 pos", {61'd0, flags}, 64'd2);
      issue(64'hFFFF_FFFF_0000_0000, 64'h1F, 6'h0, 1'b0, 1'b1, 1'b1);
      check("R9 zero", {61'd0, flags}, 64'd1);
      issue(64'h1, 64'h3F, 6'h0, 1'b0, 1'b0, 1'b0);
      check("R10 no rec", {61'd0, flags}, 64'd0);
   endtask

   initial begin
      #1;
      t_reset;
      #10;
      t_reset;
      @(negedge clk);
      rst_n = 1'b1;
      t_full_reg;
      t_full_imm;
      t_word_reg;
      t_word_imm;
      t_reverse;
      t_flags;
      t_hold;
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule